// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the small register file that sits in front of a shared-memory peer device. A host bus reaches four 32-bit registers through a single request port. One holds an interrupt enable mask, one latches pending interrupt causes, one reports the identifier this peer was given, and one is a write-only doorbell. Writing the doorbell sends a notification to another peer. The notification is a destination peer number and a vector number, and it appears on an outbound port for exactly one cycle.

Ring events that other peers aim at this peer arrive as one strobe per vector. Each one latches a bit in the status register. The local interrupt line is high while any latched cause is also enabled in the mask. Reading the status register consumes it: the read returns the latched causes and then clears them. A ring event that arrives in the same cycle as the clearing read is kept for the next read.

The peer identifier is loaded from a dedicated input at connection time. Software can only read it. The block decodes a 256-byte window. Every offset that is not one of the four registers reads as zero and ignores writes.

Top module: `dbell_regblk`

## Requirements
- R1: After reset, the mask, status and position registers read 0, `irq` is low and `db_valid` is low.
- R2: A read request (`bus_req`=1, `bus_wr`=0) produces `bus_rvalid`=1 with the data on `bus_rdata` in the following cycle. A write request produces no `bus_rvalid`.
- R3: The mask register at byte offset 0x00 stores all 32 written bits and reads them back unchanged. For example, 0xFFFFFFFF reads back as 0xFFFFFFFF.
- R4: A write to the status register at offset 0x04 ORs the written bits (bits NUM_VEC-1:0) into the latched status. Bits that are already set stay set.
- R5: A read of the status register returns its value as it stood before the read, then clears it. A second read with no new causes returns 0.
- R6: A pulse on `ring_evt[n]` sets status bit n at the next edge. If that edge also clears the status by a read, bit n is still set afterwards.
- R7: The position register at offset 0x08 ignores bus writes. It takes `pos_in` on the edge where `pos_load` is 1.
- R8: A write to the doorbell at offset 0x0C raises `db_valid` for exactly the next cycle. `db_peer` then equals write bits 31:16 and `db_vec` equals write bits 15:0, and both hold their values until the next doorbell write.
- R9: A read of the doorbell offset returns 0, produces no `db_valid` and changes no register.
- R10: Any offset in the 256-byte window other than 0x00, 0x04, 0x08 and 0x0C reads 0, and a write to it changes no register.
- R11: `irq` is 1 exactly when the bitwise AND of the status and mask registers is nonzero. It follows register changes in the cycle after the edge that makes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read completion strobe |
| ring_evt | input | NUM_VEC | Inbound per-vector ring strobes |
| pos_load | input | 1 | Load strobe for the peer position |
| pos_in | input | POS_W | Peer identifier assigned at connection |
| db_valid | output | 1 | Outbound doorbell notification strobe |
| db_peer | output | 16 | Destination peer of the last doorbell |
| db_vec | output | 16 | Vector of the last doorbell |
| irq | output | 1 | Local interrupt request |

## Verification
The hardest case to reach is an inbound ring event landing on the same edge as a consuming read of the status register. The read must return the older value while the new cause survives. Random stimulus only produces this by chance, so the bench has a dedicated operation that drives a nonzero ring vector in the same cycle as a status read. It then reads the status again and expects exactly the ring bits. Masks are written both as full patterns and as zero, so `irq` is checked in both polarities after every operation.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

   localparam int unsigned DBELL_DATA_W = 32;
   localparam int unsigned DBELL_HALF_W = DBELL_DATA_W / 2;

   // byte offsets that software decodes
   localparam int unsigned OFS_MASK = 0;
   localparam int unsigned OFS_STAT = 4;
   localparam int unsigned OFS_POS  = 8;
   localparam int unsigned OFS_BELL = 12;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_MASK = 3'd1,
      SEL_STAT = 3'd2,
      SEL_POS  = 3'd3,
      SEL_BELL = 3'd4
   } reg_sel_e;

   typedef struct packed {
      logic [DBELL_HALF_W-1:0] peer;
      logic [DBELL_HALF_W-1:0] vec;
   } bell_word_t;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
   import dbell_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(OFS_POS);
   localparam logic [ADDR_W-1:0] A_BELL = ADDR_W'(OFS_BELL);

   always_comb begin
      unique case (addr)
         A_MASK:  sel = SEL_MASK;
         A_STAT:  sel = SEL_STAT;
         A_POS:   sel = SEL_POS;
         A_BELL:  sel = SEL_BELL;
         default: sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/dbell_status.sv
module dbell_status #(
   parameter int unsigned NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] sw_set,
   input  logic               rd_clr,
   input  logic [NUM_VEC-1:0] ring,
   output logic [NUM_VEC-1:0] status_q
);

   logic [NUM_VEC-1:0] keep;
   logic [NUM_VEC-1:0] status_d;

   // clear first, then merge new causes so a same-edge ring survives
   always_comb begin
      keep     = rd_clr ? '0 : status_q;
      status_d = keep | sw_set | ring;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

endmodule

// File: rtl/dbell_out.sv
module dbell_out
   import dbell_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fire,
   input  logic [DBELL_DATA_W-1:0] wdata,
   output logic                    db_valid,
   output logic [DBELL_HALF_W-1:0] db_peer,
   output logic [DBELL_HALF_W-1:0] db_vec
);

   bell_word_t word;
   assign word = bell_word_t'(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         db_valid <= 1'b0;
         db_peer  <= '0;
         db_vec   <= '0;
      end else begin
         db_valid <= fire;
         if (fire) begin
            db_peer <= word.peer;
            db_vec  <= word.vec;
         end
      end
   end

endmodule

// File: rtl/dbell_irq.sv
module dbell_irq #(
   parameter int unsigned NUM_VEC = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] status_q,
   input  logic [NUM_VEC-1:0] enable,
   output logic               irq
);

   logic any_hit;
   assign any_hit = |(status_q & enable);

   generate
      if (IRQ_REG) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_hit;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = any_hit;
      end
   endgenerate

endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
   import dbell_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned NUM_VEC = 32,
   parameter int unsigned POS_W   = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DBELL_DATA_W-1:0] bus_wdata,
   output logic [DBELL_DATA_W-1:0] bus_rdata,
   output logic                    bus_rvalid,
   input  logic [NUM_VEC-1:0]      ring_evt,
   input  logic                    pos_load,
   input  logic [POS_W-1:0]        pos_in,
   output logic                    db_valid,
   output logic [DBELL_HALF_W-1:0] db_peer,
   output logic [DBELL_HALF_W-1:0] db_vec,
   output logic                    irq
);

   localparam int unsigned WIN_BYTES = 1 << ADDR_W;

   generate
      if (ADDR_W < 4)
         $error("dbell_regblk: ADDR_W too small for four registers");
      if (NUM_VEC < 1 || NUM_VEC > DBELL_DATA_W)
         $error("dbell_regblk: NUM_VEC must be 1..32");
      if (POS_W < 1 || POS_W > DBELL_HALF_W)
         $error("dbell_regblk: POS_W must be 1..16");
      if (WIN_BYTES < 16)
         $error("dbell_regblk: window smaller than register set");
   endgenerate

   reg_sel_e sel;
   logic     rd_en, wr_en;

   logic [DBELL_DATA_W-1:0] mask_q;
   logic [POS_W-1:0]        pos_q;
   logic [NUM_VEC-1:0]      status_q;
   logic [NUM_VEC-1:0]      sw_set;
   logic                    rd_clr;
   logic                    bell_fire;
   logic [DBELL_DATA_W-1:0] rd_mux;
   logic [DBELL_DATA_W-1:0] stat_ext;
   logic [DBELL_DATA_W-1:0] pos_ext;

   assign rd_en = bus_req & ~bus_wr;
   assign wr_en = bus_req &  bus_wr;

   dbell_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   // mask: full-width read/write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mask_q <= '0;
      else if (wr_en && sel == SEL_MASK)  mask_q <= bus_wdata;
   end

   // position: loaded only from the side input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pos_q <= '0;
      else if (pos_load) pos_q <= pos_in;
   end

   assign sw_set = (wr_en && sel == SEL_STAT) ? bus_wdata[NUM_VEC-1:0] : '0;
   assign rd_clr = rd_en && sel == SEL_STAT;

   dbell_status #(.NUM_VEC(NUM_VEC)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_set   (sw_set),
      .rd_clr   (rd_clr),
      .ring     (ring_evt),
      .status_q (status_q)
   );

   assign bell_fire = wr_en && sel == SEL_BELL;

   dbell_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (bell_fire),
      .wdata    (bus_wdata),
      .db_valid (db_valid),
      .db_peer  (db_peer),
      .db_vec   (db_vec)
   );

   dbell_irq #(.NUM_VEC(NUM_VEC), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_q (status_q),
      .enable   (mask_q[NUM_VEC-1:0]),
      .irq      (irq)
   );

   always_comb begin
      stat_ext = '0;
      stat_ext[NUM_VEC-1:0] = status_q;
      pos_ext = '0;
      pos_ext[POS_W-1:0] = pos_q;
   end

   always_comb begin
      unique case (sel)
         SEL_MASK: rd_mux = mask_q;
         SEL_STAT: rd_mux = stat_ext;
         SEL_POS:  rd_mux = pos_ext;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_en;
         if (rd_en) bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/dbell_regblk_chk.sv
module dbell_regblk_chk #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned NUM_VEC = 32,
   parameter int unsigned POS_W   = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_req,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic               bus_rvalid,
   input logic [NUM_VEC-1:0] ring_evt,
   input logic               pos_load,
   input logic               db_valid,
   input logic [15:0]        db_peer,
   input logic [15:0]        db_vec,
   input logic               irq,
   input logic [31:0]        mask_q,
   input logic [NUM_VEC-1:0] status_q,
   input logic [POS_W-1:0]   pos_q
);

   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_BELL = ADDR_W'(12);

   p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr) |=> bus_rvalid);

   p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_wr) |=> !bus_rvalid);

   p_mask_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == A_MASK) |=> mask_q == $past(bus_wdata));

   p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && bus_addr == A_STAT && ring_evt == '0) |=> status_q == '0);

   p_ring_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_evt != '0) |=> ((status_q & $past(ring_evt)) == $past(ring_evt)));

   p_pos_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pos_load |=> $stable(pos_q));

   p_bell_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == A_BELL) |=>
         (db_valid && db_peer == $past(bus_wdata[31:16]) && db_vec == $past(bus_wdata[15:0])));

   p_bell_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |-> $past(bus_req && bus_wr && bus_addr == A_BELL));

   p_bell_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !db_valid |-> (db_peer == $past(db_peer) && db_vec == $past(db_vec)));

   generate
      if (!IRQ_REG) begin : g_irq_chk
         p_irq_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ((status_q & mask_q[NUM_VEC-1:0]) != '0) |-> irq);
         p_irq_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q == '0) |-> !irq);
      end
   endgenerate

endmodule

bind dbell_regblk dbell_regblk_chk #(
   .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC), .POS_W(POS_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rvalid (bus_rvalid),
   .ring_evt   (ring_evt),
   .pos_load   (pos_load),
   .db_valid   (db_valid),
   .db_peer    (db_peer),
   .db_vec     (db_vec),
   .irq        (irq),
   .mask_q     (mask_q),
   .status_q   (status_q),
   .pos_q      (pos_q)
);

// File: tb/tb_dbell_regblk.sv
module tb_dbell_regblk;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [31:0] ring_evt = '0;
   logic        pos_load = 1'b0;
   logic [15:0] pos_in = '0;
   logic        db_valid;
   logic [15:0] db_peer;
   logic [15:0] db_vec;
   logic        irq;

   always #4 clk = ~clk;

   dbell_regblk dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .ring_evt(ring_evt), .pos_load(pos_load),
      .pos_in(pos_in), .db_valid(db_valid), .db_peer(db_peer),
      .db_vec(db_vec), .irq(irq)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model of the register file
   logic [31:0] m_mask = '0;
   logic [31:0] m_stat = '0;
   logic [15:0] m_pos  = '0;
   logic [15:0] m_peer = '0;
   logic [15:0] m_vec  = '0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic string rd_tag(input logic [7:0] a);
      case (a)
         8'd0:    return "R3";
         8'd4:    return "R5";
         8'd8:    return "R7";
         8'd12:   return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'd0:    return m_mask;
         8'd4:    return m_stat;
         8'd8:    return {16'h0, m_pos};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [7:0] unmapped_addr(input int unsigned r);
      logic [7:0] a = r[7:0];
      if (a < 8'd16 && a[1:0] == 2'b00) a = a + 8'd1;
      return a;
   endfunction

   // one access, with optional ring and position load in the same cycle
   task automatic do_op(input bit req, input bit wr, input logic [7:0] a,
                        input logic [31:0] wd, input logic [31:0] ring,
                        input bit ld, input logic [15:0] pin);
      logic [31:0] exp_rd;
      bit          is_bell;
      @(negedge clk);
      bus_req = req; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      ring_evt = ring; pos_load = ld; pos_in = pin;
      exp_rd  = model_read(a);
      is_bell = req && wr && a == 8'd12;
      // model update for the coming edge
      if (req && !wr && a == 8'd4) m_stat = ring;
      else if (req && wr && a == 8'd4) m_stat = m_stat | wd | ring;
      else m_stat = m_stat | ring;
      if (req && wr && a == 8'd0) m_mask = wd;
      if (ld) m_pos = pin;
      if (is_bell) begin m_peer = wd[31:16]; m_vec = wd[15:0]; end
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0; ring_evt = '0; pos_load = 1'b0;
      check("R2", {31'h0, bus_rvalid}, {31'h0, req && !wr});
      if (req && !wr) check(rd_tag(a), bus_rdata, exp_rd);
      check("R8", {31'h0, db_valid}, {31'h0, is_bell});
      check("R8", {db_peer, db_vec}, {m_peer, m_vec});
      check("R11", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
      @(negedge clk);
      check("R8", {31'h0, db_valid}, 32'h0);
      check("R11", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
   endtask

   task automatic rd(input logic [7:0] a);
      do_op(1'b1, 1'b0, a, 32'h0, 32'h0, 1'b0, 16'h0);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      do_op(1'b1, 1'b1, a, d, 32'h0, 1'b0, 16'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", {31'h0, irq}, 32'h0);
      check("R1", {31'h0, db_valid}, 32'h0);
      rd(8'd0); rd(8'd4); rd(8'd8);
      // R3: full-width mask
      wr(8'd0, 32'hFFFF_FFFF); rd(8'd0);
      // R4/R5: set, read, read again
      wr(8'd4, 32'h1); wr(8'd4, 32'h10); rd(8'd4); rd(8'd4);
      // R7: bus write to position ignored
      wr(8'd8, 32'h1); rd(8'd8);
      // R9: doorbell read, no effects
      rd(8'd12); rd(8'd0);
      // R8: doorbell to peer 8, vector 0
      wr(8'd12, 32'h0008_0000);
      wr(8'd12, 32'hABCD_0003);
      // R10: unmapped offsets
      wr(8'h10, 32'hDEAD_BEEF); rd(8'h10); rd(8'hFC); wr(8'h02, 32'h5);
      rd(8'd0); rd(8'd4);
      // R6: ring on the edge of a clearing read
      wr(8'd4, 32'h0000_00F0);
      do_op(1'b1, 1'b0, 8'd4, 32'h0, 32'h0000_0005, 1'b0, 16'h0);
      rd(8'd4); rd(8'd4);
      // R7: load from side input
      do_op(1'b0, 1'b0, 8'd0, 32'h0, 32'h0, 1'b1, 16'h00A5);
      rd(8'd8);
      // R11: mask off, pending cause does not interrupt
      wr(8'd0, 32'h0); wr(8'd4, 32'h2); wr(8'd0, 32'h2); rd(8'd4);
      // random phase
      for (int i = 0; i < 600; i++) begin
         int unsigned k = $urandom % 8;
         case (k)
            0: wr(8'd0, ($urandom % 2) ? $urandom : 32'h0);
            1: wr(8'd4, 32'h1 << ($urandom % 32));
            2: rd(8'(4 * ($urandom % 4)));
            3: wr(8'd12, $urandom);
            4: do_op(1'b1, 1'b0, 8'd4, 32'h0, 32'h1 << ($urandom % 32), 1'b0, 16'h0);
            5: do_op(1'b0, 1'b0, 8'd0, 32'h0, 32'h0, 1'b1, 16'($urandom));
            6: do_op(1'b1, 1'($urandom % 2), unmapped_addr($urandom), $urandom,
                      32'h0, 1'b0, 16'h0);
            default: do_op(1'b0, 1'b0, 8'd0, 32'h0, $urandom & $urandom, 1'b0, 16'h0);
         endcase
      end
      rd(8'd0); rd(8'd4); rd(8'd8);
      finish_run();
   end

endmodule